// File: doc/BRIEF.md
# Interrupt Status Collector with Write-One-to-Clear

This block gathers event pulses from the transmit path, the receive path and the DMA engines into an 8-bit pending-interrupt register. A pulse on an event input sets the matching pending bit. The bit then stays set until software writes a 1 to that bit position. The block reads the pending bits back in a 32-bit status word. The same word carries registered copies of the receive FIFO read pointer and the transmit ring read pointer, and all other positions read as zero.

A single interrupt line is raised when any pending bit is also enabled by its mask bit. Three of the events are fatal: a memory error during DMA, a transmit abort, and a receive FIFO overflow. Any of these raises a DMA-halt output, which stays high until software clears every fatal bit. A summary error output collects the five error-class bits. The block raises the receive threshold event itself. It does so whenever the receive interrupt is enabled and the receive FIFO fill count differs from a programmed depth.

Top module: `irq_status_unit`

## Requirements
- R1: During and straight after synchronous reset, the pending bits, `irq`, `dma_halt` and `err_any` are all 0.
- R2: The pending bit positions are: 0 transmit ring empty, 1 flagged frame sent, 2 link failure, 3 DMA memory error, 4 transmit abort, 6 receive underflow, 7 receive overflow. A 1 on an event input at a rising edge sets its bit, and the bit shows in `status` after that edge. Once set, a bit stays set until it is cleared.
- R3: When `wr_en` is 1 at an edge, each pending bit whose `wr_data` bit (same position, 7:0) is 1 is cleared. Bits written with 0 are unchanged. `wr_data` bits 31:8 have no effect.
- R4: If an event and a write-one-to-clear hit the same bit at the same edge, the bit ends set.
- R5: Bit 5 is set at an edge where `rx_int_en` is 1 and `rx_fill` differs from `rx_depth`. Nothing sets bit 5 when the two are equal or when `rx_int_en` is 0.
- R6: `status[11:8]` shows the value `rx_rptr` had at the previous edge.
- R7: `status[24:16]` shows the value `tx_rptr` had at the previous edge.
- R8: `status[15:12]` and `status[31:25]` always read 0.
- R9: After each edge, `irq` equals the OR over the pending bits held before that edge, each ANDed with the `irq_mask` bit at that edge. The line therefore stays high until every enabled pending bit is cleared.
- R10: After each edge, `dma_halt` is 1 exactly when any of bits 3, 4 or 7 was pending before that edge.
- R11: After each edge, `err_any` is 1 exactly when any of bits 2, 3, 4, 6 or 7 was pending before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_tx_empty | input | 1 | Transmit ring empty pulse |
| ev_tx_sent | input | 1 | Flagged frame sent pulse |
| ev_link_fail | input | 1 | Link failure pulse |
| ev_mem_err | input | 1 | DMA memory error pulse (fatal) |
| ev_tx_abort | input | 1 | Transmit abort pulse (fatal) |
| ev_rx_underflow | input | 1 | Receive underflow pulse |
| ev_rx_overflow | input | 1 | Receive FIFO overflow pulse (fatal) |
| rx_int_en | input | 1 | Enables the receive threshold event |
| rx_fill | input | 5 | Current receive FIFO entry count |
| rx_depth | input | 5 | Programmed receive threshold depth |
| rx_rptr | input | 4 | Receive FIFO read pointer to mirror |
| tx_rptr | input | 9 | Transmit ring read pointer to mirror |
| irq_mask | input | 8 | Per-bit interrupt enables |
| wr_en | input | 1 | Status write strobe |
| wr_data | input | 32 | Write data; 1 in bits 7:0 clears the matching bit |
| status | output | 32 | Readable status word |
| irq | output | 1 | Registered interrupt line |
| dma_halt | output | 1 | Registered stop request to the DMA engines |
| err_any | output | 1 | Registered error-group summary |

## Verification
The assertions assume that every input holds a defined 0 or 1 at each rising edge. They also assume that event pulses, write strobes and masks are sampled only at edges, with no meaning given to values between edges. The stimulus drives every input on the falling edge from seeded random draws. Fill count and depth are drawn from a small range so that equal and unequal pairs both occur often. Directed steps place a set and a clear on the same bit in the same cycle, write zeros and upper-bit-only data, and hold the threshold condition false.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int STAT_W  = 8;
  localparam int WORD_W  = 32;
  localparam int RXP_LSB = 8;
  localparam int TXP_LSB = 16;

  localparam int B_TX_EMPTY = 0;
  localparam int B_TX_SENT  = 1;
  localparam int B_LINK     = 2;
  localparam int B_MEM      = 3;
  localparam int B_TX_ABORT = 4;
  localparam int B_RX_THR   = 5;
  localparam int B_RX_UNDER = 6;
  localparam int B_RX_OVER  = 7;

  localparam logic [STAT_W-1:0] FATAL_MASK =
    (STAT_W'(1) << B_MEM) | (STAT_W'(1) << B_TX_ABORT) | (STAT_W'(1) << B_RX_OVER);
  localparam logic [STAT_W-1:0] ERROR_MASK =
    FATAL_MASK | (STAT_W'(1) << B_LINK) | (STAT_W'(1) << B_RX_UNDER);

  typedef logic [STAT_W-1:0] stat_vec_t;
endpackage

// File: rtl/irq_w1c_bank.sv
module irq_w1c_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] q;

  for (genvar k = 0; k < N; k++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)            q[k] <= 1'b0;
      else if (set_i[k])  q[k] <= 1'b1;
      else if (clr_i[k])  q[k] <= 1'b0;
    end

    assert_set_wins_R4: assert property (@(posedge clk) disable iff (rst)
      set_i[k] |=> q[k]);
    assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (rst)
      (clr_i[k] && !set_i[k]) |=> !q[k]);
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
      (!clr_i[k] && !set_i[k]) |=> (q[k] == $past(q[k])));
  end

  assign q_o = q;
endmodule

// File: rtl/irq_rx_threshold.sv
module irq_rx_threshold #(
  parameter int FILL_W = 5
) (
  input  logic              en_i,
  input  logic [FILL_W-1:0] fill_i,
  input  logic [FILL_W-1:0] depth_i,
  output logic              hit_o
);
  always_comb hit_o = en_i && (fill_i != depth_i);
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage
  import irq_stat_pkg::*;
#(
  parameter int N = STAT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pend_i,
  input  logic [N-1:0] mask_i,
  output logic         irq_o,
  output logic         halt_o,
  output logic         err_o
);
  localparam logic [N-1:0] FMASK = N'(FATAL_MASK);
  localparam logic [N-1:0] EMASK = N'(ERROR_MASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o  <= 1'b0;
      halt_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      irq_o  <= |(pend_i & mask_i);
      halt_o <= |(pend_i & FMASK);
      err_o  <= |(pend_i & EMASK);
    end
  end

  assert_irq_rise_R9: assert property (@(posedge clk) disable iff (rst)
    (|(pend_i & mask_i)) |=> irq_o);
  assert_irq_fall_R9: assert property (@(posedge clk) disable iff (rst)
    !(|(pend_i & mask_i)) |=> !irq_o);
  assert_halt_R10: assert property (@(posedge clk) disable iff (rst)
    (|(pend_i & FMASK)) |=> halt_o);
  assert_halt_clear_R10: assert property (@(posedge clk) disable iff (rst)
    !(|(pend_i & FMASK)) |=> !halt_o);
  assert_err_R11: assert property (@(posedge clk) disable iff (rst)
    (|(pend_i & EMASK)) |=> err_o);
  assert_halt_in_err_R11: assert property (@(posedge clk) disable iff (rst)
    halt_o |-> err_o);
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_stat_pkg::*;
#(
  parameter int FILL_W = 5,
  parameter int RXP_W  = 4,
  parameter int TXP_W  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_tx_empty,
  input  logic              ev_tx_sent,
  input  logic              ev_link_fail,
  input  logic              ev_mem_err,
  input  logic              ev_tx_abort,
  input  logic              ev_rx_underflow,
  input  logic              ev_rx_overflow,
  input  logic              rx_int_en,
  input  logic [FILL_W-1:0] rx_fill,
  input  logic [FILL_W-1:0] rx_depth,
  input  logic [RXP_W-1:0]  rx_rptr,
  input  logic [TXP_W-1:0]  tx_rptr,
  input  logic [STAT_W-1:0] irq_mask,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] status,
  output logic              irq,
  output logic              dma_halt,
  output logic              err_any
);
  localparam int RXP_MSB = RXP_LSB + RXP_W - 1;
  localparam int TXP_MSB = TXP_LSB + TXP_W - 1;

  logic      thr_hit;
  stat_vec_t set_v, clr_v, pend;
  logic [RXP_W-1:0] rxp_q;
  logic [TXP_W-1:0] txp_q;

  irq_rx_threshold #(.FILL_W(FILL_W)) u_thr (
    .en_i(rx_int_en), .fill_i(rx_fill), .depth_i(rx_depth), .hit_o(thr_hit)
  );

  always_comb begin
    set_v             = '0;
    set_v[B_TX_EMPTY] = ev_tx_empty;
    set_v[B_TX_SENT]  = ev_tx_sent;
    set_v[B_LINK]     = ev_link_fail;
    set_v[B_MEM]      = ev_mem_err;
    set_v[B_TX_ABORT] = ev_tx_abort;
    set_v[B_RX_THR]   = thr_hit;
    set_v[B_RX_UNDER] = ev_rx_underflow;
    set_v[B_RX_OVER]  = ev_rx_overflow;
    clr_v             = wr_en ? wr_data[STAT_W-1:0] : '0;
  end

  irq_w1c_bank #(.N(STAT_W)) u_bank (
    .clk(clk), .rst(rst), .set_i(set_v), .clr_i(clr_v), .q_o(pend)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rxp_q <= '0;
      txp_q <= '0;
    end else begin
      rxp_q <= rx_rptr;
      txp_q <= tx_rptr;
    end
  end

  always_comb begin
    status                  = '0;
    status[STAT_W-1:0]      = pend;
    status[RXP_MSB:RXP_LSB] = rxp_q;
    status[TXP_MSB:TXP_LSB] = txp_q;
  end

  irq_out_stage #(.N(STAT_W)) u_out (
    .clk(clk), .rst(rst), .pend_i(pend), .mask_i(irq_mask),
    .irq_o(irq), .halt_o(dma_halt), .err_o(err_any)
  );

  assert_thr_set_R5: assert property (@(posedge clk) disable iff (rst)
    (rx_int_en && (rx_fill != rx_depth)) |=> status[B_RX_THR]);
  assert_rx_mirror_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (status[RXP_MSB:RXP_LSB] == $past(rx_rptr)));
  assert_tx_mirror_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (status[TXP_MSB:TXP_LSB] == $past(tx_rptr)));
  assert_fatal_halts_R10: assert property (@(posedge clk) disable iff (rst)
    ev_mem_err |=> ##1 dma_halt);
endmodule

// File: tb/irq_status_unit_test.sv
module irq_status_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] FAT = 8'h98;
  localparam logic [7:0] ERR = 8'hDC;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_tx_empty = 0, ev_tx_sent = 0, ev_link_fail = 0, ev_mem_err = 0;
  logic ev_tx_abort = 0, ev_rx_underflow = 0, ev_rx_overflow = 0;
  logic rx_int_en = 0;
  logic [4:0] rx_fill = 0, rx_depth = 0;
  logic [3:0] rx_rptr = 0;
  logic [8:0] tx_rptr = 0;
  logic [7:0] irq_mask = 0;
  logic wr_en = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] status;
  logic irq, dma_halt, err_any;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [7:0] m_bits = 0;
  logic [3:0] m_rx = 0;
  logic [8:0] m_tx = 0;
  logic m_irq = 0, m_halt = 0, m_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_unit uut (
    .clk(clk), .rst(rst), .ev_tx_empty(ev_tx_empty), .ev_tx_sent(ev_tx_sent),
    .ev_link_fail(ev_link_fail), .ev_mem_err(ev_mem_err), .ev_tx_abort(ev_tx_abort),
    .ev_rx_underflow(ev_rx_underflow), .ev_rx_overflow(ev_rx_overflow),
    .rx_int_en(rx_int_en), .rx_fill(rx_fill), .rx_depth(rx_depth),
    .rx_rptr(rx_rptr), .tx_rptr(tx_rptr), .irq_mask(irq_mask),
    .wr_en(wr_en), .wr_data(wr_data), .status(status), .irq(irq),
    .dma_halt(dma_halt), .err_any(err_any)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] set_vec();
    logic [7:0] s;
    s = {ev_rx_overflow, ev_rx_underflow, rx_int_en && (rx_fill != rx_depth),
         ev_tx_abort, ev_mem_err, ev_link_fail, ev_tx_sent, ev_tx_empty};
    return s;
  endfunction

  function automatic logic [7:0] next_bits(input logic [7:0] cur, input logic [7:0] s,
                                           input logic we, input logic [31:0] d);
    logic [7:0] c;
    c = we ? d[7:0] : 8'h00;
    return (cur & ~c) | s;
  endfunction

  task automatic check_all();
    chk("R2 pending bits", {24'h0, status[7:0]}, {24'h0, m_bits});
    chk("R6 rx mirror", {28'h0, status[11:8]}, {28'h0, m_rx});
    chk("R7 tx mirror", {23'h0, status[24:16]}, {23'h0, m_tx});
    chk("R8 reserved zero", {25'h0, status[31:25], status[15:12]}, 32'h0);
    chk("R9 irq", {31'h0, irq}, {31'h0, m_irq});
    chk("R10 dma_halt", {31'h0, dma_halt}, {31'h0, m_halt});
    chk("R11 err_any", {31'h0, err_any}, {31'h0, m_err});
  endtask

  task automatic step();
    @(posedge clk);
    m_irq  = |(m_bits & irq_mask);
    m_halt = |(m_bits & FAT);
    m_err  = |(m_bits & ERR);
    m_bits = next_bits(m_bits, set_vec(), wr_en, wr_data);
    m_rx   = rx_rptr;
    m_tx   = tx_rptr;
    #1;
    check_all();
    @(negedge clk);
  endtask

  task automatic quiet();
    {ev_tx_empty, ev_tx_sent, ev_link_fail, ev_mem_err, ev_tx_abort,
     ev_rx_underflow, ev_rx_overflow} = '0;
    rx_int_en = 0;
    wr_en = 0;
    wr_data = 0;
  endtask

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    quiet();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 pending after reset", {24'h0, status[7:0]}, 32'h0);
    chk("R1 irq after reset", {31'h0, irq}, 32'h0);
    chk("R1 halt after reset", {31'h0, dma_halt}, 32'h0);
    chk("R1 err after reset", {31'h0, err_any}, 32'h0);
    rst = 0;

    // R2: set each event, mask all enabled
    irq_mask = 8'hFF;
    ev_tx_sent = 1; ev_mem_err = 1;
    step();
    quiet();
    step();
    chk("R2 bits held", {24'h0, status[7:0]}, 32'h0000000A);
    chk("R10 halt on mem error", {31'h0, dma_halt}, 32'h1);

    // R4: set and clear same bit same cycle
    ev_tx_sent = 1; wr_en = 1; wr_data = 32'h0000_0002;
    step();
    quiet();
    chk("R4 set beats clear", {31'h0, status[1]}, 32'h1);

    // R3: zero write and upper-bit-only write change nothing
    wr_en = 1; wr_data = 32'hFFFF_FF00;
    step();
    chk("R3 upper bits ignored", {24'h0, status[7:0]}, 32'h0000000A);
    wr_data = 32'h0000_0008;
    step();
    quiet();
    chk("R3 w1c clears bit 3", {24'h0, status[7:0]}, 32'h00000002);
    step();
    chk("R10 halt drops", {31'h0, dma_halt}, 32'h0);

    // R5: equal fill/depth, or disabled, leaves bit 5 clear
    rx_int_en = 1; rx_fill = 5'd4; rx_depth = 5'd4;
    step(); step();
    chk("R5 equal no set", {31'h0, status[5]}, 32'h0);
    rx_int_en = 0; rx_fill = 5'd9;
    step();
    chk("R5 disabled no set", {31'h0, status[5]}, 32'h0);
    rx_int_en = 1;
    step();
    chk("R5 differ sets", {31'h0, status[5]}, 32'h1);
    quiet();
    wr_en = 1; wr_data = 32'hFF;
    step();
    quiet();
    step();
    chk("R9 irq low after full clear", {31'h0, irq}, 32'h0);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      ev_tx_empty     = ($urandom_range(0, 9) == 0);
      ev_tx_sent      = ($urandom_range(0, 9) == 0);
      ev_link_fail    = ($urandom_range(0, 19) == 0);
      ev_mem_err      = ($urandom_range(0, 29) == 0);
      ev_tx_abort     = ($urandom_range(0, 29) == 0);
      ev_rx_underflow = ($urandom_range(0, 19) == 0);
      ev_rx_overflow  = ($urandom_range(0, 29) == 0);
      rx_int_en       = ($urandom_range(0, 3) == 0);
      rx_fill         = 5'($urandom_range(0, 3));
      rx_depth        = 5'($urandom_range(0, 3));
      rx_rptr         = 4'($urandom);
      tx_rptr         = 9'($urandom);
      if ($urandom_range(0, 15) == 0) irq_mask = 8'($urandom);
      wr_en           = ($urandom_range(0, 2) == 0);
      wr_data         = $urandom;
      step();
    end

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule